// File: doc/BRIEF.md
# Split-Bus Priority Arbiter with Direction Bypass

This block decides which master owns the next address phase of a shared system bus whose read and write data travel on two separate data buses. Up to eight masters raise a request, each marked as a read or a write and carrying a priority level. On every decision the arbiter picks one request and issues a one-cycle, registered, one-hot grant together with the direction of the granted transfer. A master that sees its grant drops its request; the arbiter leaves one idle cycle after every grant so that a request still asserted during the grant cycle is not granted twice.

Normally the highest priority request wins, whatever its direction, and ties between equal priorities rotate round-robin starting just after the master granted last. The read and write data buses report their own busy state. A mode input turns on high-utilization arbitration. In that mode, if the normal winner needs a data bus that is busy while the other data bus is free, the best pending request of the opposite direction is granted instead, so the idle data bus is kept in use.

The block is used beside the address path of the bus: requests, priorities and directions come straight from the masters, the busy flags come from the data-bus trackers, and the mode bit comes from a configuration register elsewhere.

Top module: `sba_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, grant is all zero and grant_wr is 0.
- R2: A decision edge with no request pending leaves grant all zero in the following cycle.
- R3: A decision edge with a request pending produces, in the following cycle, a grant with exactly one bit set; the cycle after any grant always has grant all zero, even if requests remain asserted.
- R4: With util_mode at 0, the granted master is one whose priority (field bits [i*PRIO_W +: PRIO_W] of req_prio, larger value meaning higher priority) is the largest among all pending requests, whatever their directions.
- R5: Among pending requests sharing the winning priority, the master granted is the first one found when searching upward from the index just above the last granted master, wrapping from the highest index to 0; after reset the search starts at master 0.
- R6: With util_mode at 0, the values of rd_busy and wr_busy have no effect on which master is granted.
- R7: With util_mode at 1, when the normal winner of R4 and R5 needs a busy data bus (a write needs the write bus, a read the read bus), the opposite data bus is free, and a request of the opposite direction is pending, the grant goes to the highest priority pending request of the opposite direction, ties resolved as in R5.
- R8: With util_mode at 1, when both data buses are busy, when the normal winner's data bus is free, or when no opposite-direction request is pending, the normal winner of R4 and R5 is granted.
- R9: In a cycle where grant is non-zero, grant_wr equals the direction flag the granted master presented (req_wr, 1 for write, 0 for read) at the decision edge.
- R10: A grant bit is only ever set for a master whose req bit was 1 at the decision edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | Per-master request |
| req_wr | input | NUM_MASTERS | Per-master direction, 1 write, 0 read |
| req_prio | input | NUM_MASTERS*PRIO_W | Per-master priority fields, master i at [i*PRIO_W +: PRIO_W] |
| rd_busy | input | 1 | Read data bus is occupied |
| wr_busy | input | 1 | Write data bus is occupied |
| util_mode | input | 1 | Enables high-utilization direction bypass |
| grant | output | NUM_MASTERS | Registered one-hot address grant |
| grant_wr | output | 1 | Direction of the granted transfer, 1 write |

## Verification
Every result of this block sits behind one register: the grant and its direction appear in the cycle after the rising edge that sampled the requests, priorities, busy flags and mode, and the forced idle grant appears one cycle after that. The bench changes inputs only on the falling edge, lets one rising edge take the decision and reads grant and grant_wr 1 ns after it, then clears the requests and reads the idle cycle after the next rising edge, so the arbiter is never in its recovery cycle when a new scenario begins. The round-robin pointer carries across scenarios, so each tie test first places it with a single-master grant before the contested request.

// File: rtl/sba_pkg.sv
package sba_pkg;

   // Direction carried by every request and by the grant.
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } dir_e;

   // Largest master count one segment supports.
   localparam int unsigned MAX_MASTERS = 8;
   // Widest priority field accepted.
   localparam int unsigned MAX_PRIO_W  = 4;

endpackage

// File: rtl/sba_rr_pick.sv
// Picks, among candidate masters, the one of highest priority; ties are
// resolved by searching upward from the index just above ptr.
module sba_rr_pick #(
   parameter int unsigned NUM_MASTERS = 8,
   parameter int unsigned PRIO_W      = 2,
   localparam int unsigned IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic [NUM_MASTERS-1:0]        cand,
   input  logic [NUM_MASTERS*PRIO_W-1:0] prio,
   input  logic [IDX_W-1:0]              ptr,
   output logic [NUM_MASTERS-1:0]        pick_oh,
   output logic [IDX_W-1:0]              pick_idx,
   output logic                          pick_valid
);

   logic [PRIO_W-1:0] best_prio;
   logic              found;
   logic [IDX_W-1:0]  best_idx;

   always_comb begin
      found     = 1'b0;
      best_prio = '0;
      best_idx  = '0;
      for (int k = 0; k < NUM_MASTERS; k++) begin
         int unsigned j;
         j = (int'(ptr) + 1 + k) % NUM_MASTERS;
         if (cand[j]) begin
            // Strictly greater keeps the first one met in rotation order.
            if (!found || (prio[j*PRIO_W +: PRIO_W] > best_prio)) begin
               found     = 1'b1;
               best_prio = prio[j*PRIO_W +: PRIO_W];
               best_idx  = IDX_W'(j);
            end
         end
      end
   end

   always_comb begin
      pick_oh = '0;
      if (found) begin
         pick_oh[best_idx] = 1'b1;
      end
   end

   assign pick_idx   = best_idx;
   assign pick_valid = found;

endmodule

// File: rtl/sba_bypass_sel.sv
// Chooses between the normal winner and the best opposite-direction
// request, depending on data-bus occupancy and the utilization mode.
module sba_bypass_sel
   import sba_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 8,
   parameter bit          BYPASS_IMPL = 1'b1,
   localparam int unsigned IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic [NUM_MASTERS-1:0] req_wr,
   input  logic                   rd_busy,
   input  logic                   wr_busy,
   input  logic                   util_mode,
   input  logic [NUM_MASTERS-1:0] all_oh,
   input  logic [IDX_W-1:0]       all_idx,
   input  logic                   all_valid,
   input  logic [NUM_MASTERS-1:0] rd_oh,
   input  logic [IDX_W-1:0]       rd_idx,
   input  logic                   rd_valid,
   input  logic [NUM_MASTERS-1:0] wr_oh,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic                   wr_valid,
   output logic [NUM_MASTERS-1:0] sel_oh,
   output logic [IDX_W-1:0]       sel_idx,
   output logic                   sel_valid,
   output dir_e                   sel_dir
);

   dir_e dflt_dir;
   logic take_alt;

   assign dflt_dir = (|(all_oh & req_wr)) ? DIR_WRITE : DIR_READ;

   generate
      if (BYPASS_IMPL) begin : g_bypass
         logic need_busy;
         logic other_free;
         logic other_valid;

         always_comb begin
            if (dflt_dir == DIR_WRITE) begin
               need_busy   = wr_busy;
               other_free  = !rd_busy;
               other_valid = rd_valid;
            end else begin
               need_busy   = rd_busy;
               other_free  = !wr_busy;
               other_valid = wr_valid;
            end
         end

         assign take_alt = util_mode && all_valid && need_busy
                           && other_free && other_valid;
      end else begin : g_no_bypass
         logic unused_bypass;
         assign unused_bypass = &{1'b0, rd_busy, wr_busy, util_mode, rd_valid, wr_valid};
         assign take_alt      = 1'b0;
      end
   endgenerate

   always_comb begin
      sel_oh    = all_oh;
      sel_idx   = all_idx;
      sel_valid = all_valid;
      sel_dir   = dflt_dir;
      if (take_alt) begin
         if (dflt_dir == DIR_WRITE) begin
            sel_oh  = rd_oh;
            sel_idx = rd_idx;
            sel_dir = DIR_READ;
         end else begin
            sel_oh  = wr_oh;
            sel_idx = wr_idx;
            sel_dir = DIR_WRITE;
         end
      end
   end

endmodule

// File: rtl/sba_grant_reg.sv
// Registers the chosen grant for one cycle, forces an idle cycle after
// every grant and keeps the round-robin pointer.
module sba_grant_reg
   import sba_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 8,
   localparam int unsigned IDX_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] sel_oh,
   input  logic [IDX_W-1:0]       sel_idx,
   input  logic                   sel_valid,
   input  dir_e                   sel_dir,
   output logic [NUM_MASTERS-1:0] grant,
   output logic                   grant_wr,
   output logic [IDX_W-1:0]       rr_ptr
);

   logic recovering;
   logic accept;

   assign recovering = |grant;
   assign accept     = sel_valid && !recovering;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant    <= '0;
         grant_wr <= 1'b0;
      end else if (accept) begin
         grant    <= sel_oh;
         grant_wr <= (sel_dir == DIR_WRITE);
      end else begin
         grant    <= '0;
         grant_wr <= 1'b0;
      end
   end

   // Reset value makes the first search begin at master 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= IDX_W'(NUM_MASTERS - 1);
      end else if (accept) begin
         rr_ptr <= sel_idx;
      end
   end

endmodule

// File: rtl/sba_arbiter.sv
module sba_arbiter
   import sba_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 8,
   parameter int unsigned PRIO_W      = 2,
   parameter bit          BYPASS_IMPL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_MASTERS-1:0]        req,
   input  logic [NUM_MASTERS-1:0]        req_wr,
   input  logic [NUM_MASTERS*PRIO_W-1:0] req_prio,
   input  logic                          rd_busy,
   input  logic                          wr_busy,
   input  logic                          util_mode,
   output logic [NUM_MASTERS-1:0]        grant,
   output logic                          grant_wr
);

   localparam int unsigned IDX_W   = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
   localparam int unsigned N_PICKS = 3;   // all, reads only, writes only

   generate
      if (NUM_MASTERS < 2 || NUM_MASTERS > MAX_MASTERS) begin : g_bad_masters
         $error("sba_arbiter: NUM_MASTERS must lie in 2..8");
      end
      if (PRIO_W < 1 || PRIO_W > MAX_PRIO_W) begin : g_bad_prio
         $error("sba_arbiter: PRIO_W must lie in 1..4");
      end
   endgenerate

   logic [IDX_W-1:0]       rr_ptr;
   logic [NUM_MASTERS-1:0] cand     [N_PICKS];
   logic [NUM_MASTERS-1:0] pick_oh  [N_PICKS];
   logic [IDX_W-1:0]       pick_idx [N_PICKS];
   logic                   pick_vld [N_PICKS];

   assign cand[0] = req;
   assign cand[1] = req & ~req_wr;
   assign cand[2] = req & req_wr;

   generate
      for (genvar g = 0; g < N_PICKS; g++) begin : g_pick
         sba_rr_pick #(
            .NUM_MASTERS (NUM_MASTERS),
            .PRIO_W      (PRIO_W)
         ) i_pick (
            .cand       (cand[g]),
            .prio       (req_prio),
            .ptr        (rr_ptr),
            .pick_oh    (pick_oh[g]),
            .pick_idx   (pick_idx[g]),
            .pick_valid (pick_vld[g])
         );
      end
   endgenerate

   logic [NUM_MASTERS-1:0] sel_oh;
   logic [IDX_W-1:0]       sel_idx;
   logic                   sel_valid;
   dir_e                   sel_dir;

   sba_bypass_sel #(
      .NUM_MASTERS (NUM_MASTERS),
      .BYPASS_IMPL (BYPASS_IMPL)
   ) i_bypass (
      .req_wr    (req_wr),
      .rd_busy   (rd_busy),
      .wr_busy   (wr_busy),
      .util_mode (util_mode),
      .all_oh    (pick_oh[0]),
      .all_idx   (pick_idx[0]),
      .all_valid (pick_vld[0]),
      .rd_oh     (pick_oh[1]),
      .rd_idx    (pick_idx[1]),
      .rd_valid  (pick_vld[1]),
      .wr_oh     (pick_oh[2]),
      .wr_idx    (pick_idx[2]),
      .wr_valid  (pick_vld[2]),
      .sel_oh    (sel_oh),
      .sel_idx   (sel_idx),
      .sel_valid (sel_valid),
      .sel_dir   (sel_dir)
   );

   sba_grant_reg #(
      .NUM_MASTERS (NUM_MASTERS)
   ) i_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_oh    (sel_oh),
      .sel_idx   (sel_idx),
      .sel_valid (sel_valid),
      .sel_dir   (sel_dir),
      .grant     (grant),
      .grant_wr  (grant_wr),
      .rr_ptr    (rr_ptr)
   );

   // R3: never more than one grant bit
   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R3: idle cycle after every grant
   assert_grant_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |=> (grant == '0));

   // R2: nothing pending, nothing granted
   assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (grant == '0));

   // R10: grants only go to masters that were requesting
   assert_grant_had_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((grant & ~$past(req)) == '0));

   // R9: reported direction follows the granted master's flag
   assert_grant_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((grant == '0) || (grant_wr == (|(grant & $past(req_wr))))));

   // R1: direction output quiet while no grant is shown
   assert_dir_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0) |-> !grant_wr);

endmodule

// File: tb/test_sba_arbiter.sv
`timescale 1ns/1ps
module test_sba_arbiter;

   localparam int N  = 8;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  req_wr = '0;
   logic [N*PW-1:0] req_prio = '0;
   logic          rd_busy = 1'b0;
   logic          wr_busy = 1'b0;
   logic          util_mode = 1'b0;
   logic [N-1:0]  grant;
   logic          grant_wr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   sba_arbiter #(.NUM_MASTERS(N), .PRIO_W(PW)) i_sba_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_prio(req_prio),
      .rd_busy(rd_busy), .wr_busy(wr_busy), .util_mode(util_mode),
      .grant(grant), .grant_wr(grant_wr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_master(input int m, input logic wr, input int p);
      req[m]              = 1'b1;
      req_wr[m]           = wr;
      req_prio[m*PW +: PW] = PW'(p);
   endtask

   task automatic clear_all();
      req = '0; req_wr = '0; req_prio = '0;
   endtask

   // Inputs already staged at a falling edge; decide, check, then idle.
   task automatic decide(input string tag, input logic [N-1:0] exp_g, input logic exp_wr);
      @(posedge clk); #1;
      check({tag, " grant"}, 32'(grant), 32'(exp_g));
      check({"R9 ", tag, " grant_wr"}, 32'(grant_wr), 32'(exp_wr));
      @(negedge clk);
      clear_all();
      @(posedge clk); #1;
      check({"R3 ", tag, " idle after"}, 32'(grant), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      set_master(3, 1'b1, 2);
      repeat (2) @(posedge clk);
      #1 check("R1 grant in reset", 32'(grant), 32'd0);
      check("R1 grant_wr in reset", 32'(grant_wr), 32'd0);
      @(negedge clk);
      clear_all();
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 grant first cycle", 32'(grant), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_idle();
      clear_all();
      @(posedge clk); #1;
      check("R2 no request", 32'(grant), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_gap();
      set_master(0, 1'b0, 1);
      @(posedge clk); #1;
      check("R3 first grant", 32'(grant), 32'h01);
      @(posedge clk); #1;
      check("R3 held request no regrant", 32'(grant), 32'd0);
      @(posedge clk); #1;
      check("R10 R3 regrant after gap", 32'(grant), 32'h01);
      @(negedge clk);
      clear_all();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_priority();
      set_master(1, 1'b0, 1); set_master(4, 1'b1, 3); set_master(6, 1'b0, 2);
      decide("R4 top priority write", 8'h10, 1'b1);
      set_master(2, 1'b1, 0); set_master(7, 1'b0, 2);
      decide("R4 top priority read", 8'h80, 1'b0);
   endtask

   task automatic t_busy_ignored();
      util_mode = 1'b0; wr_busy = 1'b1; rd_busy = 1'b0;
      set_master(1, 1'b0, 1); set_master(4, 1'b1, 3); set_master(6, 1'b0, 2);
      decide("R6 wr busy mode off", 8'h10, 1'b1);
      wr_busy = 1'b0; rd_busy = 1'b1;
      set_master(3, 1'b0, 3); set_master(5, 1'b1, 1);
      decide("R6 rd busy mode off", 8'h08, 1'b0);
      rd_busy = 1'b0;
   endtask

   task automatic t_round_robin();
      set_master(5, 1'b0, 2);
      decide("R5 place pointer", 8'h20, 1'b0);
      set_master(2, 1'b0, 2); set_master(5, 1'b0, 2); set_master(6, 1'b1, 2);
      decide("R5 next above pointer", 8'h40, 1'b1);
      set_master(2, 1'b0, 2); set_master(5, 1'b0, 2);
      decide("R5 wrap to low index", 8'h04, 1'b0);
      set_master(2, 1'b0, 2); set_master(5, 1'b0, 2);
      decide("R5 rotate past last", 8'h20, 1'b0);
   endtask

   task automatic t_bypass();
      util_mode = 1'b1; wr_busy = 1'b1; rd_busy = 1'b0;
      set_master(1, 1'b0, 1); set_master(4, 1'b1, 3); set_master(6, 1'b0, 2);
      decide("R7 read passes blocked write", 8'h40, 1'b0);
      wr_busy = 1'b0; rd_busy = 1'b1;
      set_master(0, 1'b0, 3); set_master(3, 1'b1, 0); set_master(7, 1'b1, 1);
      decide("R7 write passes blocked read", 8'h80, 1'b1);
      wr_busy = 1'b1; rd_busy = 1'b1;
      set_master(1, 1'b0, 1); set_master(4, 1'b1, 3);
      decide("R8 both busy", 8'h10, 1'b1);
      wr_busy = 1'b0; rd_busy = 1'b1;
      set_master(1, 1'b0, 1); set_master(4, 1'b1, 3);
      decide("R8 winner bus free", 8'h10, 1'b1);
      wr_busy = 1'b1; rd_busy = 1'b0;
      set_master(2, 1'b1, 1); set_master(4, 1'b1, 3);
      decide("R8 no opposite request", 8'h10, 1'b1);
      util_mode = 1'b0; wr_busy = 1'b0; rd_busy = 1'b0;
   endtask

   initial begin
      t_reset();
      t_idle();
      t_gap();
      t_priority();
      t_busy_ignored();
      t_round_robin();
      t_bypass();
      t_idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule